// File: doc/BRIEF.md
# Buffered Word-Program Command Sequencer

This block is the command-interface state machine that runs a buffered word-program operation on a flash device. It takes synchronous write cycles and decodes them as commands. Each cycle carries an address, a 16-bit data word and a write strobe. A setup byte opens the operation. The next write is always the word count. Then come exactly that many plus one data words, which are stored in an internal write buffer. A confirm byte closes the operation.

After a valid confirm, the block issues a one-cycle start pulse to a program engine. With the pulse it presents the start address and the count, and it offers a read port into the write buffer. It then waits for the engine's done pulse.

While an operation is in progress, the read data port returns the status register instead of array data. An address that leaves the starting block, an oversized count or a wrong confirm byte aborts the operation. An abort raises the sequence-error bits and programs nothing. Status reads stay selected until the host clears the error or returns to array reads.

Top module: `bufprog_seq`

## Requirements
- R1: After reset the block is in array-read mode (`rdData` equals `arrayData`), the error bits are clear, the ready bit is set and `pgmStart` is low.
- R2: The status word is `rdData[7]` = ready (1 when no program is running), with `rdData[5]` and `rdData[4]` both equal to the sequence-error flag; all other bits of `rdData` are 0. Writing E8h in idle starts a buffered program and selects status reads.
- R3: The first write after E8h is always taken as the word count, even when its low byte is 70h; such a value is never decoded as a command.
- R4: A count value N (0 to MAX_WORDS-1) makes the block collect exactly N+1 data writes, stored in order at buffer index 0..N. After that, a D0h write pulses `pgmStart` for one cycle in the following cycle, with `pgmAddr` equal to the address of the count write and `pgmCount` equal to N. The buffer contents are readable through `engIdx`/`engData`.
- R5: A count value above MAX_WORDS-1 aborts the operation with the sequence-error flag set.
- R6: A data write whose address differs from the count-write address in any bit above the low BLK_W bits aborts with the sequence-error flag set, and no program starts.
- R7: Any byte other than D0h in the confirm position aborts with the sequence-error flag set, and `pgmStart` stays low.
- R8: From the start pulse until `pgmDone` is seen, the ready bit reads 0 and all writes are ignored. Afterwards the ready bit reads 1 and status reads stay selected.
- R9: In idle, FFh selects array reads without touching the error flag. 50h clears the error flag and selects array reads. After an abort, status reads stay selected until one of these is written.
- R10: In idle, 70h selects status reads, and any other byte leaves the mode and the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write cycle strobe |
| wrAddr | input | ADDR_W | Write cycle word address |
| wrData | input | 16 | Write cycle data |
| arrayData | input | 16 | Array read data returned in array-read mode |
| rdData | output | 16 | Read data: array data or status word |
| pgmStart | output | 1 | One-cycle program request to the engine |
| pgmAddr | output | ADDR_W | Program start address |
| pgmCount | output | IDX_W | Word count minus one |
| pgmDone | input | 1 | Engine completion pulse |
| engIdx | input | IDX_W | Engine read index into the write buffer |
| engData | output | 16 | Write buffer word at `engIdx` |

## Verification
The bench builds the block with a 12-bit address, 6 block-offset bits and an 8-word buffer. With these values, the largest legal count (7) and the first rejected count (8) are both a few writes away. A word at the last address of a block and a word just past it can be placed with small addresses. The small buffer also makes the value 70h an out-of-range count, so a write that is wrongly decoded as a status command gives a different status word from one correctly taken as a count.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_COUNT,
    S_DATA,
    S_CONFIRM,
    S_BUSY
  } seqState_t;

  typedef struct packed {
    logic latchCount;
    logic wrBuf;
    logic setErr;
    logic clrErr;
  } dpStrobe_t;

  localparam logic [7:0] OP_SETUP   = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;

endpackage

// File: rtl/bufprog_ctrl.sv
module bufprog_ctrl
  import bufprog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] cmdByte,
  input  logic       countBad,
  input  logic       inBlock,
  input  logic       lastWord,
  input  logic       pgmDone,
  output dpStrobe_t  strb,
  output logic       pgmStart,
  output logic       statusMode,
  output logic       busy
);

  seqState_t state, nextState;
  logic nextMode;
  logic startNext;

  always_comb begin
    nextState = state;
    nextMode  = statusMode;
    startNext = 1'b0;
    strb      = '0;
    case (state)
      S_IDLE: begin
        if (wrEn) begin
          case (cmdByte)
            OP_SETUP: begin
              nextState = S_COUNT;
              nextMode  = 1'b1;
            end
            OP_STATUS: nextMode = 1'b1;
            OP_CLEAR: begin
              strb.clrErr = 1'b1;
              nextMode    = 1'b0;
            end
            OP_ARRAY: nextMode = 1'b0;
            default: ;
          endcase
        end
      end
      S_COUNT: begin
        if (wrEn) begin
          if (countBad) begin
            strb.setErr = 1'b1;
            nextState   = S_IDLE;
          end else begin
            strb.latchCount = 1'b1;
            nextState       = S_DATA;
          end
        end
      end
      S_DATA: begin
        if (wrEn) begin
          if (!inBlock) begin
            strb.setErr = 1'b1;
            nextState   = S_IDLE;
          end else begin
            strb.wrBuf = 1'b1;
            if (lastWord) nextState = S_CONFIRM;
          end
        end
      end
      S_CONFIRM: begin
        if (wrEn) begin
          if (cmdByte == OP_CONFIRM) begin
            startNext = 1'b1;
            nextState = S_BUSY;
          end else begin
            strb.setErr = 1'b1;
            nextState   = S_IDLE;
          end
        end
      end
      S_BUSY: begin
        if (pgmDone) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      statusMode <= 1'b0;
      pgmStart   <= 1'b0;
    end else begin
      state      <= nextState;
      statusMode <= nextMode;
      pgmStart   <= startNext;
    end
  end

  assign busy = (state == S_BUSY);

  // R4: a start pulse only follows a D0h write
  a_r4_start_after_confirm: assert property (@(posedge clk) disable iff (!rstN)
    pgmStart |-> $past(wrEn && cmdByte == OP_CONFIRM));

  // R7: an abort never leads to a start pulse
  a_r7_abort_no_start: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |=> !pgmStart);

  // R8: busy holds until the engine reports done
  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !pgmDone) |=> busy);

  // R8: a start pulse is followed by busy
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    pgmStart |-> busy);

endmodule

// File: rtl/bufprog_dp.sv
module bufprog_dp
  import bufprog_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BLK_W     = 16,
  parameter int MAX_WORDS = 512,
  localparam int IDX_W    = $clog2(MAX_WORDS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic [IDX_W-1:0]  engIdx,
  output logic              countBad,
  output logic              inBlock,
  output logic              lastWord,
  output logic              seqErr,
  output logic [ADDR_W-1:0] pgmAddr,
  output logic [IDX_W-1:0]  pgmCount,
  output logic [15:0]       engData
);

  localparam logic [15:0] COUNT_LIMIT = 16'(MAX_WORDS - 1);

  logic [15:0]      wordMem [MAX_WORDS];
  logic [IDX_W-1:0] idx;

  assign countBad = (wrData > COUNT_LIMIT);
  assign inBlock  = (wrAddr[ADDR_W-1:BLK_W] == pgmAddr[ADDR_W-1:BLK_W]);
  assign lastWord = (idx == pgmCount);
  assign engData  = wordMem[engIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pgmAddr  <= '0;
      pgmCount <= '0;
      idx      <= '0;
      seqErr   <= 1'b0;
    end else begin
      if (strb.latchCount) begin
        pgmAddr  <= wrAddr;
        pgmCount <= wrData[IDX_W-1:0];
        idx      <= '0;
      end else if (strb.wrBuf) begin
        idx <= idx + 1'b1;
      end
      if (strb.setErr)      seqErr <= 1'b1;
      else if (strb.clrErr) seqErr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrBuf) wordMem[idx] <= wrData;
  end

  // R6: the buffer is only written with an in-block address
  a_r6_store_in_block: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBuf |-> inBlock);

  // R4: the fill index never passes the loaded count
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBuf |-> (idx <= pgmCount));

  // R5: an out-of-range count is never accepted
  a_r5_count_ok: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchCount |-> !countBad);

  // R9: the error flag stays until cleared
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (seqErr && !strb.clrErr) |=> seqErr);

endmodule

// File: rtl/bufprog_seq.sv
module bufprog_seq
  import bufprog_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BLK_W     = 16,
  parameter int MAX_WORDS = 512,
  localparam int IDX_W    = $clog2(MAX_WORDS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic [15:0]       arrayData,
  output logic [15:0]       rdData,
  output logic              pgmStart,
  output logic [ADDR_W-1:0] pgmAddr,
  output logic [IDX_W-1:0]  pgmCount,
  input  logic              pgmDone,
  input  logic [IDX_W-1:0]  engIdx,
  output logic [15:0]       engData
);

  dpStrobe_t strb;
  logic countBad, inBlock, lastWord, seqErr;
  logic statusMode, busy;
  logic [7:0] statusWord;

  bufprog_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .cmdByte    (wrData[7:0]),
    .countBad   (countBad),
    .inBlock    (inBlock),
    .lastWord   (lastWord),
    .pgmDone    (pgmDone),
    .strb       (strb),
    .pgmStart   (pgmStart),
    .statusMode (statusMode),
    .busy       (busy)
  );

  bufprog_dp #(
    .ADDR_W    (ADDR_W),
    .BLK_W     (BLK_W),
    .MAX_WORDS (MAX_WORDS)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .engIdx   (engIdx),
    .countBad (countBad),
    .inBlock  (inBlock),
    .lastWord (lastWord),
    .seqErr   (seqErr),
    .pgmAddr  (pgmAddr),
    .pgmCount (pgmCount),
    .engData  (engData)
  );

  assign statusWord = {~busy, 1'b0, seqErr, seqErr, 4'h0};
  assign rdData     = statusMode ? {8'h00, statusWord} : arrayData;

endmodule

// File: tb/bufprog_seq_test.sv
module bufprog_seq_test;

  localparam int ADDR_W    = 12;
  localparam int BLK_W     = 6;
  localparam int MAX_WORDS = 8;
  localparam int IDX_W     = $clog2(MAX_WORDS);
  localparam logic [15:0] ARR = 16'hA5A5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] arrayData = ARR;
  logic [15:0] rdData;
  logic pgmStart;
  logic [ADDR_W-1:0] pgmAddr;
  logic [IDX_W-1:0] pgmCount;
  logic pgmDone = 1'b0;
  logic [IDX_W-1:0] engIdx = '0;
  logic [15:0] engData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bufprog_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .MAX_WORDS(MAX_WORDS)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .arrayData(arrayData), .rdData(rdData), .pgmStart(pgmStart),
    .pgmAddr(pgmAddr), .pgmCount(pgmCount), .pgmDone(pgmDone),
    .engIdx(engIdx), .engData(engData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finishEngine();
    @(negedge clk); pgmDone = 1'b1;
    @(negedge clk); pgmDone = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 array data", rdData, ARR);
    chk("R1 no start", pgmStart, 0);
    wr(12'h000, 16'h0070);
    chk("R1 ready, no error", rdData, 16'h0080);
    wr(12'h000, 16'h00FF);
  endtask

  task automatic t_mode_cmds();
    wr(12'h020, 16'h0070);
    chk("R10 status mode", rdData, 16'h0080);
    wr(12'h020, 16'h0033);
    chk("R10 other byte ignored", rdData, 16'h0080);
    wr(12'h020, 16'h00FF);
    chk("R9 FFh to array", rdData, ARR);
    wr(12'h020, 16'h0012);
    chk("R10 other byte keeps array", rdData, ARR);
  endtask

  task automatic t_full_program();
    logic [15:0] vals [4] = '{16'h1111, 16'h2222, 16'h0070, 16'hBEEF};
    wr(12'h100, 16'h00E8);
    chk("R2 setup selects status", rdData, 16'h0080);
    wr(12'h104, 16'h0003);
    chk("R4 count accepted", rdData, 16'h0080);
    for (int i = 0; i < 4; i++) begin
      wr(12'h104 + ADDR_W'(i), vals[i]);
      chk("R4 no start during load", pgmStart, 0);
    end
    wr(12'h104, 16'h00D0);
    chk("R4 start pulse", pgmStart, 1);
    chk("R4 start address", pgmAddr, 12'h104);
    chk("R4 count", pgmCount, 3);
    chk("R8 busy status", rdData, 16'h0000);
    @(negedge clk);
    chk("R4 start one cycle", pgmStart, 0);
    for (int i = 0; i < 4; i++) begin
      engIdx = IDX_W'(i);
      #1;
      chk("R4 buffer word", engData, vals[i]);
    end
    wr(12'h104, 16'h00FF);
    chk("R8 write ignored while busy", rdData, 16'h0000);
    wr(12'h104, 16'h00E8);
    chk("R8 setup ignored while busy", rdData, 16'h0000);
    finishEngine();
    chk("R8 ready after done", rdData, 16'h0080);
    wr(12'h104, 16'h00FF);
    chk("R9 back to array", rdData, ARR);
  endtask

  task automatic t_count_70();
    wr(12'h200, 16'h00E8);
    wr(12'h200, 16'h0070);
    chk("R3 70h taken as oversized count", rdData, 16'h00B0);
    wr(12'h200, 16'h0050);
    chk("R9 clear to array", rdData, ARR);
    wr(12'h200, 16'h0070);
    chk("R9 error cleared", rdData, 16'h0080);
    wr(12'h200, 16'h00FF);
  endtask

  task automatic t_count_edge();
    wr(12'h300, 16'h00E8);
    wr(12'h300, 16'h0008);
    chk("R5 count 8 aborts", rdData, 16'h00B0);
    wr(12'h300, 16'h0050);
    wr(12'h340, 16'h00E8);
    wr(12'h340, 16'h0007);
    chk("R5 count 7 accepted", rdData, 16'h0080);
    for (int i = 0; i < 8; i++) wr(12'h340 + ADDR_W'(i), 16'hC000 + 16'(i));
    chk("R4 full buffer no error", rdData, 16'h0080);
    wr(12'h340, 16'h00D0);
    chk("R4 start full buffer", pgmStart, 1);
    chk("R4 max count", pgmCount, 7);
    engIdx = 3'd7;
    #1;
    chk("R4 last buffer word", engData, 16'hC007);
    finishEngine();
    wr(12'h340, 16'h00FF);
  endtask

  task automatic t_block_edge();
    wr(12'h13F, 16'h00E8);
    wr(12'h13F, 16'h0001);
    wr(12'h13F, 16'h0001);
    chk("R6 last in-block address ok", rdData, 16'h0080);
    wr(12'h140, 16'h0002);
    chk("R6 out-of-block abort", rdData, 16'h00B0);
    chk("R6 no start", pgmStart, 0);
    wr(12'h140, 16'h00D0);
    chk("R6 confirm after abort ignored", pgmStart, 0);
    chk("R9 status held after abort", rdData, 16'h00B0);
    wr(12'h140, 16'h00FF);
    chk("R9 FFh selects array", rdData, ARR);
    wr(12'h140, 16'h0070);
    chk("R9 FFh kept error", rdData, 16'h00B0);
    wr(12'h140, 16'h0050);
  endtask

  task automatic t_bad_confirm();
    wr(12'h080, 16'h00E8);
    wr(12'h080, 16'h0000);
    wr(12'h080, 16'h5555);
    wr(12'h080, 16'h0070);
    chk("R7 bad confirm aborts", rdData, 16'h00B0);
    chk("R7 no start", pgmStart, 0);
    @(negedge clk);
    chk("R7 still no start", pgmStart, 0);
    wr(12'h080, 16'h0050);
    chk("R9 clear after bad confirm", rdData, ARR);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_cmds();
    t_full_program();
    t_count_70();
    t_count_edge();
    t_block_edge();
    t_bad_confirm();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule